// File: doc/BRIEF.md
# Adder-Subtractor with Condition Flags

This block is a purely combinational two's-complement arithmetic unit of parameterised width. One ripple-carry adder serves three arithmetic operations: add, subtract and negate. For subtract and negate, the second operand passes through a bank of XOR gates driven by a single invert control, and the same control forces the adder carry-in high. Negate also forces the first adder input to zero. A fourth operation widens a narrow field, taken from the low bits of the first operand, to the full width by copying its top bit upward or by filling with zeros.

Every operation produces a result and four condition flags: negative, zero, carry and overflow. The carry flag is the raw carry out of the top bit. It is not inverted into a borrow. The overflow flag comes from comparing the carry into the top bit with the carry out of it. The block holds no state. A surrounding design that wants a flag register or a pipeline stage adds it around this block. Because no data is stored or queued, there is no handshake and no back-pressure. Every output follows the inputs in the same cycle.

Top module: `addsub_flags_unit`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals `op_a + op_b` modulo 2^N.
- R2: With `op_sel` = 2'b01, `result` equals `op_a + ~op_b + 1`, which is `op_a - op_b` modulo 2^N.
- R3: With `op_sel` = 2'b10, `result` equals `0 + ~op_b + 1`. Negating the most negative value (only bit N-1 set) returns that same value with `flag_v` = 1. Negating 0 returns 0 with `flag_v` = 0 and `flag_c` = 1.
- R4: For codes 00, 01 and 10, `flag_c` is the carry out of bit N-1 of the shared adder. After a subtract it is 1 exactly when `op_a` >= `op_b` taken as unsigned.
- R5: For codes 00, 01 and 10, `flag_v` is the carry into bit N-1 XOR the carry out of bit N-1. It is 1 exactly when the true signed result lies outside [-2^(N-1), 2^(N-1)-1].
- R6: For every code, `flag_n` equals `result[N-1]`, and `flag_z` is 1 exactly when all bits of `result` are 0.
- R7: With `op_sel` = 2'b11, the field is `op_a[M-1:0]`, which also forms `result[M-1:0]`. When `ext_signed` = 1, bits N-1..M copy `op_a[M-1]`. When `ext_signed` = 0, those bits are 0. In both cases `flag_c` = 0 and `flag_v` = 0, and `op_b` has no effect.
- R8: All outputs are combinational functions of the present inputs. A change of inputs between clock edges shows at the outputs without any clock edge.
- R9: At N = 4: 0111 + 0001 gives 1000 with `flag_v` = 1. 0101 + 1101 gives 0010 with `flag_c` = 1 and `flag_v` = 0. 1011 + 1100 gives 0111 with `flag_v` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand; its low M bits are the field for extend |
| op_b | input | N | Second operand; the value negated by code 10 |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 extend |
| ext_signed | input | 1 | For extend: 1 copies the field's top bit upward, 0 fills with zeros |
| result | output | N | Arithmetic or extended result |
| flag_n | output | 1 | Negative: top bit of result |
| flag_z | output | 1 | Zero: result is all zeros |
| flag_c | output | 1 | Raw carry out of the top adder bit; 0 for extend |
| flag_v | output | 1 | Signed overflow; 0 for extend |

## Verification
The main instance is built with N = 4 and M = 2. At that width every operand pair can be driven for each arithmetic code, 768 combinations in all, and every field value can be tried in both extend modes. Each output is compared against a reference computed from true signed and unsigned arithmetic. This covers all carry and overflow corners, including negation of the most negative value and the wrap from 0111 to 1000. A second instance with the default N = 8 and M = 4 gets directed cases, to confirm that the width parameters take effect.

// File: rtl/addsub_flags_pkg.sv
`timescale 1ns/1ps
package addsub_flags_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_EXT = 2'b11
  } arith_op_e;

  // Flag bundle leaving the result stage
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cond_flags_t;
endpackage

// File: rtl/operand_conditioner.sv
`timescale 1ns/1ps
// Builds the two adder inputs and carry-in from the operation code.
module operand_conditioner
  import addsub_flags_pkg::*;
#(
  parameter int N = 8
) (
  input  arith_op_e    op,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic [N-1:0] x_out,
  output logic [N-1:0] y_out,
  output logic         cin_out
);
  logic invert_ctl;
  logic clear_a;

  always_comb begin
    invert_ctl = (op == OP_SUB) || (op == OP_NEG);
    clear_a    = (op == OP_NEG);
  end

  // XOR bank: each operand bit against the shared invert control
  for (genvar i = 0; i < N; i++) begin : g_xor_bank
    assign y_out[i] = b_in[i] ^ invert_ctl;
    assign x_out[i] = a_in[i] & ~clear_a;
  end

  assign cin_out = invert_ctl;
endmodule

// File: rtl/ripple_adder.sv
`timescale 1ns/1ps
// Full-adder chain exposing the carry into and out of the top bit.
module ripple_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out_msb
);
  logic [N:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic p;
    assign p          = x[i] ^ y[i];
    assign sum[i]     = p ^ chain[i];
    assign chain[i+1] = (x[i] & y[i]) | (chain[i] & p);
  end

  assign c_into_msb = chain[N-1];
  assign c_out_msb  = chain[N];
endmodule

// File: rtl/field_extender.sv
`timescale 1ns/1ps
// Widens the low M bits of the source to N bits, signed or unsigned.
module field_extender #(
  parameter int N = 8,
  parameter int M = 4
) (
  input  logic [N-1:0] src,
  input  logic         signed_mode,
  output logic [N-1:0] widened
);
  localparam int UPPER = N - M;

  logic fill_bit;

  assign fill_bit = signed_mode & src[M-1];
  assign widened  = {{UPPER{fill_bit}}, src[M-1:0]};
endmodule

// File: rtl/result_flags.sv
`timescale 1ns/1ps
// Selects between adder and extender outputs and forms the flags.
module result_flags
  import addsub_flags_pkg::*;
#(
  parameter int N = 8
) (
  input  arith_op_e    op,
  input  logic [N-1:0] sum,
  input  logic         c_into_msb,
  input  logic         c_out_msb,
  input  logic [N-1:0] widened,
  output logic [N-1:0] res,
  output cond_flags_t  flags
);
  logic use_ext;

  always_comb begin
    use_ext     = (op == OP_EXT);
    res         = use_ext ? widened : sum;
    flags.neg   = res[N-1];
    flags.zero  = ~|res;
    flags.carry = use_ext ? 1'b0 : c_out_msb;
    flags.ovf   = use_ext ? 1'b0 : (c_into_msb ^ c_out_msb);
  end
endmodule

// File: rtl/addsub_flags_unit.sv
`timescale 1ns/1ps
module addsub_flags_unit
  import addsub_flags_pkg::*;
#(
  parameter int N = 8,
  parameter int M = 4
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         ext_signed,
  output logic [N-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  arith_op_e    op;
  logic [N-1:0] add_x;
  logic [N-1:0] add_y;
  logic         add_cin;
  logic [N-1:0] add_sum;
  logic         carry_in_top;
  logic         carry_out_top;
  logic [N-1:0] ext_val;
  cond_flags_t  fl;

  assign op = arith_op_e'(op_sel);

  operand_conditioner #(.N(N)) u_cond (
    .op      (op),
    .a_in    (op_a),
    .b_in    (op_b),
    .x_out   (add_x),
    .y_out   (add_y),
    .cin_out (add_cin)
  );

  ripple_adder #(.N(N)) u_adder (
    .x          (add_x),
    .y          (add_y),
    .cin        (add_cin),
    .sum        (add_sum),
    .c_into_msb (carry_in_top),
    .c_out_msb  (carry_out_top)
  );

  field_extender #(.N(N), .M(M)) u_ext (
    .src         (op_a),
    .signed_mode (ext_signed),
    .widened     (ext_val)
  );

  result_flags #(.N(N)) u_flags (
    .op         (op),
    .sum        (add_sum),
    .c_into_msb (carry_in_top),
    .c_out_msb  (carry_out_top),
    .widened    (ext_val),
    .res        (result),
    .flags      (fl)
  );

  assign flag_n = fl.neg;
  assign flag_z = fl.zero;
  assign flag_c = fl.carry;
  assign flag_v = fl.ovf;
endmodule

// File: rtl/addsub_flags_unit_chk.sv
`timescale 1ns/1ps
// Property checker bound to the top; immediate checks on settled inputs.
module addsub_flags_unit_chk #(
  parameter int N = 8,
  parameter int M = 4
) (
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic [1:0]   op_sel,
  input logic         ext_signed,
  input logic [N-1:0] result,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v
);
  logic [N:0]   wide_add;
  logic [N-1:0] neg_ref;
  logic         known;

  always_comb begin
    wide_add = {1'b0, op_a} + {1'b0, op_b};
    neg_ref  = '0 - op_b;
    known    = !$isunknown({op_a, op_b, op_sel, ext_signed});
  end

  always_comb begin
    if (known) begin
      if (op_sel == 2'b00) begin
        p_add_sum_r1: assert (result == wide_add[N-1:0])
          else $error("R1 add result mismatch");
        p_add_carry_r4: assert (flag_c == wide_add[N])
          else $error("R4 add carry mismatch");
        // R5: operands of opposite sign never overflow
        p_no_overflow_r5: assert (!(op_a[N-1] != op_b[N-1]) || !flag_v)
          else $error("R5 overflow with opposite signs");
        // R5: overflow means equal operand signs and a flipped result sign
        p_add_overflow_r5: assert (flag_v == ((op_a[N-1] == op_b[N-1]) && (result[N-1] != op_a[N-1])))
          else $error("R5 add overflow mismatch");
      end
      if (op_sel == 2'b01) begin
        p_sub_diff_r2: assert (result == op_a - op_b)
          else $error("R2 subtract result mismatch");
        p_sub_carry_r4: assert (flag_c == (op_a >= op_b))
          else $error("R4 subtract carry mismatch");
      end
      if (op_sel == 2'b10) begin
        p_neg_value_r3: assert (result == neg_ref)
          else $error("R3 negate result mismatch");
        p_neg_carry_r3: assert (flag_c == (op_b == '0))
          else $error("R3 negate carry mismatch");
      end
      if (op_sel == 2'b11) begin
        p_ext_flags_r7: assert (!flag_c && !flag_v)
          else $error("R7 extend flags not clear");
        p_ext_low_r7: assert (result[M-1:0] == op_a[M-1:0])
          else $error("R7 extend field mismatch");
        p_ext_fill_r7: assert (result[N-1] == (ext_signed & op_a[M-1]))
          else $error("R7 extend fill mismatch");
      end
      p_zero_flag_r6: assert (flag_z == (result == '0))
        else $error("R6 zero flag mismatch");
      p_neg_flag_r6: assert (flag_n == result[N-1])
        else $error("R6 negative flag mismatch");
    end
  end
endmodule

bind addsub_flags_unit addsub_flags_unit_chk #(.N(N), .M(M)) u_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .op_sel     (op_sel),
  .ext_signed (ext_signed),
  .result     (result),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .flag_v     (flag_v)
);

// File: tb/addsub_flags_unit_bench.sv
`timescale 1ns/1ps
module addsub_flags_unit_bench;
  localparam int W  = 4;
  localparam int FW = 2;
  localparam int W8 = 8;
  localparam int F8 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // Width-4 instance
  logic [W-1:0] a, b, res;
  logic [1:0]   sel;
  logic         es, fn, fz, fc, fv;

  addsub_flags_unit #(.N(W), .M(FW)) u_addsub_flags_unit (
    .op_a(a), .op_b(b), .op_sel(sel), .ext_signed(es),
    .result(res), .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv)
  );

  // Default-width instance
  logic [W8-1:0] a8, b8, res8;
  logic [1:0]    sel8;
  logic          es8, fn8, fz8, fc8, fv8;

  addsub_flags_unit u_addsub_flags_unit_w8 (
    .op_a(a8), .op_b(b8), .op_sel(sel8), .ext_signed(es8),
    .result(res8), .flag_n(fn8), .flag_z(fz8), .flag_c(fc8), .flag_v(fv8)
  );

  // Reference: returns {v, c, z, n, result} with result in the low w bits
  function automatic logic [31:0] ref_model(input int op, input int ua, input int ub,
                                            input int sgn, input int w, input int m);
    int mask, half, sum, res_v, sa, sb, truth, c, v, f;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    sa = (ua >= half) ? ua - (1 << w) : ua;
    sb = (ub >= half) ? ub - (1 << w) : ub;
    c = 0; v = 0; sum = 0; truth = 0;
    case (op)
      0: begin sum = ua + ub;                  truth = sa + sb; end
      1: begin sum = ua + ((~ub) & mask) + 1;  truth = sa - sb; end
      2: begin sum = ((~ub) & mask) + 1;       truth = -sb;     end
      default: ;
    endcase
    if (op < 3) begin
      res_v = sum & mask;
      c = (sum >> w) & 1;
      v = (truth > half - 1 || truth < -half) ? 1 : 0;
    end else begin
      f = ua & ((1 << m) - 1);
      if (sgn != 0 && ((f >> (m - 1)) & 1) == 1) res_v = f | (mask & ~((1 << m) - 1));
      else res_v = f;
    end
    ref_model = 32'(res_v);
    ref_model[w]   = ((res_v >> (w - 1)) & 1) == 1;
    ref_model[w+1] = (res_v == 0);
    ref_model[w+2] = (c == 1);
    ref_model[w+3] = (v == 1);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] out4();
    out4 = {24'd0, fv, fc, fz, fn, res};
  endfunction

  function automatic logic [31:0] out8();
    out8 = {20'd0, fv8, fc8, fz8, fn8, res8};
  endfunction

  task automatic drive4(input int op, input int ua, input int ub, input int sgn);
    @(negedge clk);
    sel = 2'(op); a = W'(ua); b = W'(ub); es = sgn[0];
    #2;
  endtask

  task automatic t_reset_state();
    drive4(0, 0, 0, 0);
    check("R6", "idle zero inputs", out4(), ref_model(0, 0, 0, 0, W, FW));
    check("R6", "idle zero flag", 32'(fz), 32'd1);
  endtask

  task automatic t_examples();
    drive4(0, 7, 1, 0);
    check("R9", "0111+0001", out4(), {24'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1000});
    drive4(0, 5, 13, 0);
    check("R9", "0101+1101", out4(), {24'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0010});
    drive4(0, 11, 12, 0);
    check("R9", "1011+1100", out4(), {24'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0111});
  endtask

  task automatic t_negate_corners();
    drive4(2, 9, 8, 0);
    check("R3", "negate 1000", out4(), {24'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1000});
    drive4(2, 15, 0, 0);
    check("R3", "negate 0", out4(), {24'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000});
    drive4(1, 3, 5, 0);
    check("R4", "3-5 no carry", 32'(fc), 32'd0);
    drive4(1, 5, 5, 0);
    check("R4", "5-5 carry set", 32'(fc), 32'd1);
  endtask

  task automatic t_exhaustive(input int op, input string tag);
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        drive4(op, ia, ib, 0);
        check(tag, $sformatf("a=%0d b=%0d", ia, ib), out4(), ref_model(op, ia, ib, 0, W, FW));
      end
    end
  endtask

  task automatic t_extend();
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int sg = 0; sg < 2; sg++) begin
        drive4(3, ia, 15 - ia, sg);
        check("R7", $sformatf("extend a=%0d s=%0d", ia, sg), out4(), ref_model(3, ia, 15 - ia, sg, W, FW));
      end
    end
    // R7: op_b has no effect on the extend result
    drive4(3, 2, 0, 1);
    check("R7", "extend 10 signed b=0", out4(), {24'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1110});
    drive4(3, 2, 15, 1);
    check("R7", "extend 10 signed b=15", out4(), {24'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1110});
  endtask

  task automatic t_combinational();
    @(posedge clk);
    #1;
    sel = 2'b00; a = 4'd3; b = 4'd2; es = 1'b0;
    #1;
    check("R8", "mid-cycle add", out4(), ref_model(0, 3, 2, 0, W, FW));
    sel = 2'b01;
    #1;
    check("R8", "mid-cycle op change", out4(), ref_model(1, 3, 2, 0, W, FW));
  endtask

  task automatic t_width8();
    int cases [6][3] = '{'{0, 127, 1}, '{0, 200, 100}, '{1, 0, 1},
                         '{2, 128, 0}, '{1, 128, 1}, '{2, 0, 0}};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sel8 = 2'(cases[k][0]); a8 = 8'(cases[k][1]); b8 = 8'(cases[k][2]); es8 = 1'b0;
      #2;
      check("R5", $sformatf("w8 case %0d", k), out8(),
            ref_model(cases[k][0], cases[k][1], cases[k][2], 0, W8, F8));
    end
    @(negedge clk);
    sel8 = 2'b11; a8 = 8'h3A; b8 = 8'h00; es8 = 1'b1;
    #2;
    check("R7", "w8 extend signed 1010", out8(), {20'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFA});
    es8 = 1'b0;
    #2;
    check("R7", "w8 extend zero 1010", out8(), {20'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0A});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sel = '0; es = 1'b0;
    a8 = '0; b8 = '0; sel8 = '0; es8 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_examples();
    t_negate_corners();
    t_exhaustive(0, "R1 R4 R5 R6");
    t_exhaustive(1, "R2 R4 R5 R6");
    t_exhaustive(2, "R3 R4 R5 R6");
    t_extend();
    t_combinational();
    t_width8();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule